// File: doc/BRIEF.md
# Coherent Input Capture Register

This block records the time of an event. A free-running counter value comes in as a port. When the selected edge arrives on an asynchronous input pin, the block copies the whole counter value into a capture register in one transfer. The pin first passes through a two-flop synchronizer, and the edge is then detected against the previous synchronized level. Software reads the 16-bit result over an 8-bit path, as a high byte and then a low byte.

A capture must not change the register between the two byte reads. A high-byte read therefore blocks any transfer at the end of that bus cycle. A capture that falls in this blocked cycle is held pending and completes in the next unblocked cycle. It then latches the counter value of that later cycle, so the event is never lost. Each completed capture sets a sticky flag, which software clears with a write-one strobe. Reset clears the synchronizer, the pending state and the flag, but it leaves the captured value untouched.

Top module: `icap_coherent`

## Requirements
- R1: A level change on `pin_i` that is first sampled at clock edge k is detected in the cycle after edge k+1. When enabled and not blocked, it loads the counter value present in that cycle at edge k+2. Seen from the cycle in which the pin changed, the stored value is that cycle's counter value plus 2 when the counter advances by one each cycle.
- R2: `edge_sel_i` selects the capturing edge: 2'b00 captures nothing, 2'b01 captures rising edges, 2'b10 captures falling edges, and 2'b11 captures both.
- R3: A transfer copies all CNT_W bits at once. `rd_data_o` shows bits 15:8 while `rd_hi_i` is high, shows bits 7:0 while only `rd_lo_i` is high, and is 0 when neither is high.
- R4: Reset clears the capture flag and the synchronizer and drops any pending capture. The captured value survives reset.
- R5: No transfer takes place at the end of a cycle in which `rd_hi_i` is high. A high read followed in the next cycle by a low read returns both bytes of one stored value.
- R6: A capture blocked by a high read stays pending. It completes at the end of the first cycle without `rd_hi_i`, with that cycle's counter value.
- R7: Each completed transfer sets `flag_o`, which holds until a cycle with `flag_clr_i` high. If a transfer and a clear fall in the same cycle, the flag ends up set.
- R8: A low-byte read does not delay or block a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | CNT_W | Free-running counter value |
| pin_i | input | 1 | Asynchronous event input |
| edge_sel_i | input | 2 | Capture edge select |
| rd_hi_i | input | 1 | High-byte read strobe |
| rd_lo_i | input | 1 | Low-byte read strobe |
| flag_clr_i | input | 1 | Write-one clear of the capture flag |
| rd_data_o | output | CNT_W/2 | Selected byte of the capture register |
| flag_o | output | 1 | Sticky capture flag |

## Verification
A missing or stuck pending bit shows up within three cycles: a capture that was blocked by a high read either never changes the value read back, or it carries the wrong count. A hold-off that is missing or one cycle late shows up immediately, because the low byte read right after a high byte no longer matches the earlier value. Faults in the synchronizer depth or in the edge decode shift the stored count by a cycle, or set the flag where none is expected. The bench detects these on the first affected capture.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } icap_edge_e;

    typedef struct packed {
        logic pend;
        logic flag;
    } icap_ctrl_t;

endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] edge_sel_i,
    output logic       edge_o
);
    import icap_pkg::*;

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   prev_d, prev_q;
    logic                   level;
    logic                   rise, fall;
    icap_edge_e             mode;

    assign level = sync_q[SYNC_STAGES-1];

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
        prev_d = level;
        mode   = icap_edge_e'(edge_sel_i);
        rise   = level & ~prev_q;
        fall   = ~level & prev_q;
        unique case (mode)
            EDGE_RISE: edge_o = rise;
            EDGE_FALL: edge_o = fall;
            EDGE_BOTH: edge_o = rise | fall;
            default:   edge_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/icap_ctrl.sv
module icap_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic rd_hi_i,
    input  logic flag_clr_i,
    output logic load_o,
    output logic pend_o,
    output logic flag_o
);
    import icap_pkg::*;

    icap_ctrl_t ctrl_d, ctrl_q;
    logic       want;

    always_comb begin
        want        = edge_i | ctrl_q.pend;
        load_o      = want & ~rd_hi_i;
        ctrl_d.pend = want & rd_hi_i;
        ctrl_d.flag = load_o | (ctrl_q.flag & ~flag_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign pend_o = ctrl_q.pend;
    assign flag_o = ctrl_q.flag;

endmodule

// File: rtl/icap_latch.sv
module icap_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] cap_o
);
    logic [CNT_W-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = load_i ? count_i : cap_q;
    end

    // Deliberately without reset: the stored value outlives reset.
    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign cap_o = cap_q;

endmodule

// File: rtl/icap_coherent.sv
module icap_coherent #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   count_i,
    input  logic               pin_i,
    input  logic [1:0]         edge_sel_i,
    input  logic               rd_hi_i,
    input  logic               rd_lo_i,
    input  logic               flag_clr_i,
    output logic [CNT_W/2-1:0] rd_data_o,
    output logic               flag_o
);
    localparam int BYTE_W = CNT_W / 2;
    localparam int LANES  = 2;

    logic              edge_det;
    logic              cap_load;
    logic              pend;
    logic [CNT_W-1:0]  cap_val;
    logic [BYTE_W-1:0] lane [LANES];

    icap_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .edge_sel_i (edge_sel_i),
        .edge_o     (edge_det)
    );

    icap_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_i     (edge_det),
        .rd_hi_i    (rd_hi_i),
        .flag_clr_i (flag_clr_i),
        .load_o     (cap_load),
        .pend_o     (pend),
        .flag_o     (flag_o)
    );

    icap_latch #(.CNT_W(CNT_W)) u_latch (
        .clk     (clk),
        .load_i  (cap_load),
        .count_i (count_i),
        .cap_o   (cap_val)
    );

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane[b] = cap_val[b*BYTE_W +: BYTE_W];
    end

    always_comb begin
        if (rd_hi_i)      rd_data_o = lane[1];
        else if (rd_lo_i) rd_data_o = lane[0];
        else              rd_data_o = '0;
    end

endmodule

// File: rtl/icap_checker.sv
module icap_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_hi_i,
    input logic             rd_lo_i,
    input logic             flag_clr_i,
    input logic             edge_det,
    input logic             cap_load,
    input logic             pend,
    input logic [CNT_W-1:0] count_i,
    input logic [CNT_W-1:0] cap_val,
    input logic             flag_o
);

    assert_xfer_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_load |=> cap_val == $past(count_i));

    assert_reset_flag_R4: assert property (@(posedge clk)
        !rst_n |=> !flag_o);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_i |=> $stable(cap_val));

    assert_defer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_det && rd_hi_i) |=> (pend && (cap_load || rd_hi_i)));

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_load |=> flag_o);

    assert_flag_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !cap_load) |=> !flag_o);

    assert_lo_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_det && rd_lo_i && !rd_hi_i) |-> cap_load);

endmodule

bind icap_coherent icap_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_hi_i    (rd_hi_i),
    .rd_lo_i    (rd_lo_i),
    .flag_clr_i (flag_clr_i),
    .edge_det   (edge_det),
    .cap_load   (cap_load),
    .pend       (pend),
    .count_i    (count_i),
    .cap_val    (cap_val),
    .flag_o     (flag_o)
);

// File: tb/test_icap_coherent.sv
`timescale 1ns/1ps
module test_icap_coherent;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = 16'h12F0;
    logic        pin = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic        rd_hi = 1'b0;
    logic        rd_lo = 1'b0;
    logic        clr = 1'b0;
    logic [7:0]  rd_data;
    logic        flag;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    icap_coherent i_icap_coherent (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_i    (cnt),
        .pin_i      (pin),
        .edge_sel_i (sel),
        .rd_hi_i    (rd_hi),
        .rd_lo_i    (rd_lo),
        .flag_clr_i (clr),
        .rd_data_o  (rd_data),
        .flag_o     (flag)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 16'd1;

    // {sel[1:0], start level, end level, expect capture}
    localparam logic [4:0] VEC [8] = '{
        5'b01_01_1, 5'b01_10_0, 5'b10_10_1, 5'b10_01_0,
        5'b11_01_1, 5'b11_10_1, 5'b00_01_0, 5'b00_10_0
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read16(output logic [15:0] v);
        @(negedge clk); rd_hi = 1'b1; #1 v[15:8] = rd_data;
        @(negedge clk); rd_hi = 1'b0; rd_lo = 1'b1; #1 v[7:0] = rd_data;
        @(negedge clk); rd_lo = 1'b0;
    endtask

    task automatic arm(input logic [1:0] s);
        @(negedge clk); sel = 2'b00; pin = 1'b0; step(4);
        clr = 1'b1; @(negedge clk); clr = 1'b0; sel = s; step(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c0, last, hl;
        step(3);
        check("R4 flag after reset", {15'd0, flag}, 16'd0);
        check("R3 idle read data", {8'd0, rd_data}, 16'd0);
        rst_n = 1'b1;
        step(3);

        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sel = 2'b00; pin = VEC[i][2]; step(4);
            clr = 1'b1; @(negedge clk); clr = 1'b0; sel = VEC[i][4:3]; step(1);
            pin = VEC[i][1]; c0 = cnt; step(4);
            check("R2 edge select flag", {15'd0, flag}, {15'd0, VEC[i][0]});
            if (VEC[i][0]) begin
                read16(v);
                check("R1 R3 captured count", v, c0 + 16'd2);
                last = c0 + 16'd2;
            end
        end

        // R5/R6: edge lands in the cycle of a high read
        arm(2'b01);
        pin = 1'b1; c0 = cnt; step(2);
        rd_hi = 1'b1; #1 hl[15:8] = rd_data;
        @(negedge clk); rd_hi = 1'b0; rd_lo = 1'b1; #1 hl[7:0] = rd_data;
        @(negedge clk); rd_lo = 1'b0;
        check("R5 coherent pair", hl, last);
        check("R7 flag after deferred", {15'd0, flag}, 16'd1);
        read16(v);
        check("R6 deferred capture value", v, c0 + 16'd3);
        last = v;

        // R6: two consecutive high reads keep it pending
        arm(2'b01);
        pin = 1'b1; c0 = cnt; step(2);
        rd_hi = 1'b1; step(2); rd_hi = 1'b0; step(2);
        read16(v);
        check("R6 double hold value", v, c0 + 16'd4);

        // R8: low read does not delay
        arm(2'b01);
        pin = 1'b1; c0 = cnt; step(2);
        rd_lo = 1'b1; @(negedge clk); rd_lo = 1'b0; step(1);
        read16(v);
        check("R8 low read no delay", v, c0 + 16'd2);

        // R7: clear in the same cycle as a transfer keeps flag set
        arm(2'b01);
        pin = 1'b1; c0 = cnt; step(2);
        clr = 1'b1; @(negedge clk); clr = 1'b0; step(1);
        check("R7 set wins over clear", {15'd0, flag}, 16'd1);
        clr = 1'b1; @(negedge clk); clr = 1'b0; step(1);
        check("R7 clear alone", {15'd0, flag}, 16'd0);
        step(3);
        check("R7 flag stays clear", {15'd0, flag}, 16'd0);
        read16(v);
        last = v;
        check("R1 value from set-wins capture", v, c0 + 16'd2);

        // R4: set flag then reset; value persists
        arm(2'b11);
        pin = 1'b1; c0 = cnt; step(4);
        last = c0 + 16'd2;
        sel = 2'b00; pin = 1'b0; step(4);
        rst_n = 1'b0; step(2);
        check("R4 flag in reset", {15'd0, flag}, 16'd0);
        rst_n = 1'b1; step(2);
        check("R4 flag after release", {15'd0, flag}, 16'd0);
        read16(v);
        check("R4 value kept across reset", v, last);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule